// File: doc/BRIEF.md
# Power-Up Strap Capture and Frequency Select

This block samples the configuration straps that share pins with clock outputs: a 4-bit frequency code, a CPU interface mode strap, a drive multiplier strap and a power-management mode strap. It holds them for the rest of operation, and it switches each dual-use pin from input to output once the capture has happened. The capture happens exactly once after power-up reset. In the mode where the CPU strap is 1, the capture waits until an active-low power-good input is first sampled low. In the mode where the CPU strap is 0, the power-good function is unused and the capture takes place on the first clock after reset.

A small control register lets software replace the strapped frequency code. The replacement is possible only while an override enable bit in that register is already set. The block drives the effective frequency code, which is either the latched straps or the software value, to the downstream frequency decoder. It also drives a single enable that holds every clock output off until the capture.

Top module: `strap_latch_top`

## Requirements
- R1: While rst_ni is low, clk_en_o = 0, pin_oe_o = 0, fs_lat_o = 0 and reg_rdata_o = 0.
- R2: With the CPU mode strap at 0, all straps are captured on the first rising clock edge after reset release, regardless of pwrgd_ni.
- R3: With the CPU mode strap at 1, nothing is captured while pwrgd_ni is high. The straps are captured on the first rising edge at which pwrgd_ni is sampled low.
- R4: After the capture, changes on the strap inputs and on pwrgd_ni have no effect on the latched strap outputs or on clk_en_o.
- R5: clk_en_o is 0 before the capture and 1 from then on. pin_oe_o[6:0] (bits 3:0 for the frequency pins, 4 for the CPU mode pin, 5 for the multiplier pin, 6 for the power-management pin) is all ones after the capture. pin_oe_o[7] (the power-good pin) is 1 after the capture only if the latched CPU mode is 0.
- R6: The reg_rdata_o layout is: bit 7 = 0, bit 6 = FS2, bit 5 = FS1, bit 4 = FS0, bit 3 = override enable, bit 2 = 0, bit 1 = FS3, bit 0 = latched CPU mode. The FS bits show the latched straps when the override is off and the software code when it is on.
- R7: A register write always loads bit 3. Its FS bits (6:4, 1) are loaded only if the override bit was already 1 before that write.
- R8: With the override on, a write loads the software code from bits 6, 5, 4 and 1, and fs_eff_o takes that code on the next cycle.
- R9: Clearing the override returns fs_eff_o and the readback to the latched straps.
- R10: At the capture, the software code is preset to the strapped code, so setting the override alone leaves fs_eff_o unchanged.
- R11: With the override off, fs_eff_o equals fs_lat_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| fs_strap_i | input | 4 | Raw frequency strap pin levels (bit n = FSn) |
| cpu_mode_strap_i | input | 1 | Raw CPU interface mode strap |
| mult_strap_i | input | 1 | Raw drive multiplier strap |
| pm_mode_strap_i | input | 1 | Raw power-management mode strap |
| pwrgd_ni | input | 1 | Active-low power-good input |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register readback |
| fs_lat_o | output | 4 | Latched frequency strap |
| cpu_mode_o | output | 1 | Latched CPU mode |
| mult_o | output | 1 | Latched multiplier strap |
| pm_mode_o | output | 1 | Latched power-management mode strap |
| fs_eff_o | output | 4 | Effective frequency code |
| clk_en_o | output | 1 | Clock output enable |
| pin_oe_o | output | 8 | Per-pin output enable for the dual-use pins |

## Verification
The bench sweeps all 128 strap combinations: every frequency code, both multiplier and power-management values, and both CPU modes. This separates a capture that drops or swaps any field from a correct one. In the power-good mode the power-good input is held high for one to three cycles before it falls, which tells a capture gated on that input apart from one taken at reset release. After each capture the bench flips the straps and pulses power-good again, which catches any second capture. On a subset of codes a sequence of register writes tells apart enable-before-write gating, the preset of the software code, and the return to the straps.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int FS_W  = 4;
  localparam int REG_W = 8;

  // register bit positions that software decodes
  localparam int FS0_BIT  = 4;
  localparam int FS1_BIT  = 5;
  localparam int FS2_BIT  = 6;
  localparam int FS3_BIT  = 1;
  localparam int OVR_BIT  = 3;
  localparam int MODE_BIT = 0;

  typedef struct packed {
    logic            pm_mode;
    logic            mult;
    logic            cpu_mode;
    logic [FS_W-1:0] fs;
  } strap_t;

  localparam int STRAP_W = $bits(strap_t);

  typedef enum logic {ST_WAIT, ST_DONE} lat_state_e;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  strap_t raw_i,
  input  logic   pwrgd_ni,
  output strap_t lat_o,
  output logic   done_o,
  output logic   fire_o
);
  lat_state_e state_q;
  strap_t     lat_q;

  // mode 0 ignores power-good; mode 1 waits for its first low sample
  assign fire_o = (state_q == ST_WAIT) && (!raw_i.cpu_mode || !pwrgd_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      lat_q   <= '0;
    end else if (fire_o) begin
      state_q <= ST_DONE;
      lat_q   <= raw_i;
    end
  end

  assign lat_o  = lat_q;
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/strap_fs_reg.sv
module strap_fs_reg
  import strap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [FS_W-1:0]  raw_fs_i,
  input  logic [FS_W-1:0]  lat_fs_i,
  input  logic             cpu_mode_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [FS_W-1:0]  fs_eff_o
);
  logic            ovr_q;
  logic [FS_W-1:0] sw_fs_q;
  logic [FS_W-1:0] wr_fs;

  assign wr_fs = {wdata_i[FS3_BIT], wdata_i[FS2_BIT], wdata_i[FS1_BIT], wdata_i[FS0_BIT]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q   <= 1'b0;
      sw_fs_q <= '0;
    end else begin
      if (fire_i) sw_fs_q <= raw_fs_i;
      if (we_i) begin
        ovr_q <= wdata_i[OVR_BIT];
        if (ovr_q) sw_fs_q <= wr_fs;  // enable must precede the write
      end
    end
  end

  assign fs_eff_o = ovr_q ? sw_fs_q : lat_fs_i;

  always_comb begin
    rdata_o           = '0;
    rdata_o[FS0_BIT]  = fs_eff_o[0];
    rdata_o[FS1_BIT]  = fs_eff_o[1];
    rdata_o[FS2_BIT]  = fs_eff_o[2];
    rdata_o[FS3_BIT]  = fs_eff_o[3];
    rdata_o[OVR_BIT]  = ovr_q;
    rdata_o[MODE_BIT] = cpu_mode_i;
  end
endmodule

// File: rtl/strap_pin_dir.sv
module strap_pin_dir #(
  parameter int N_STRAP = 7
) (
  input  logic           done_i,
  input  logic           cpu_mode_i,
  output logic [N_STRAP:0] oe_o
);
  for (genvar g = 0; g < N_STRAP; g++) begin : g_strap_oe
    assign oe_o[g] = done_i;
  end
  // power-good pin turns into an output only when its function is unused
  assign oe_o[N_STRAP] = done_i && !cpu_mode_i;
endmodule

// File: rtl/strap_latch_top.sv
module strap_latch_top
  import strap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FS_W-1:0]  fs_strap_i,
  input  logic             cpu_mode_strap_i,
  input  logic             mult_strap_i,
  input  logic             pm_mode_strap_i,
  input  logic             pwrgd_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic [FS_W-1:0]  fs_lat_o,
  output logic             cpu_mode_o,
  output logic             mult_o,
  output logic             pm_mode_o,
  output logic [FS_W-1:0]  fs_eff_o,
  output logic             clk_en_o,
  output logic [STRAP_W:0] pin_oe_o
);
  strap_t raw, lat;
  logic   done, fire;

  assign raw = '{pm_mode: pm_mode_strap_i, mult: mult_strap_i,
                 cpu_mode: cpu_mode_strap_i, fs: fs_strap_i};

  strap_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (raw),
    .pwrgd_ni(pwrgd_ni),
    .lat_o   (lat),
    .done_o  (done),
    .fire_o  (fire)
  );

  strap_fs_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .raw_fs_i  (raw.fs),
    .lat_fs_i  (lat.fs),
    .cpu_mode_i(lat.cpu_mode),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .fs_eff_o  (fs_eff_o)
  );

  strap_pin_dir #(.N_STRAP(STRAP_W)) u_dir (
    .done_i    (done),
    .cpu_mode_i(lat.cpu_mode),
    .oe_o      (pin_oe_o)
  );

  assign fs_lat_o   = lat.fs;
  assign cpu_mode_o = lat.cpu_mode;
  assign mult_o     = lat.mult;
  assign pm_mode_o  = lat.pm_mode;
  assign clk_en_o   = done;
endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwrgd_ni,
  input logic [7:0] reg_rdata_o,
  input logic [3:0] fs_lat_o,
  input logic       cpu_mode_o,
  input logic       mult_o,
  input logic       pm_mode_o,
  input logic [3:0] fs_eff_o,
  input logic       clk_en_o,
  input logic [7:0] pin_oe_o
);
  assert_latch_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |=> clk_en_o && $stable(fs_lat_o) && $stable(cpu_mode_o)
                 && $stable(mult_o) && $stable(pm_mode_o));

  assert_pwrgd_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(clk_en_o) && cpu_mode_o) |-> $past(!pwrgd_ni));

  assert_oe_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> (pin_oe_o == 8'h00));

  assert_pg_pin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> (pin_oe_o[7] == !cpu_mode_o));

  assert_rd_map_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[7] && !reg_rdata_o[2] && (reg_rdata_o[0] == cpu_mode_o));

  assert_eff_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_eff_o == {reg_rdata_o[1], reg_rdata_o[6], reg_rdata_o[5], reg_rdata_o[4]});

  assert_eff_strap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[3] |-> (fs_eff_o == fs_lat_o));
endmodule

bind strap_latch_top strap_latch_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwrgd_ni   (pwrgd_ni),
  .reg_rdata_o(reg_rdata_o),
  .fs_lat_o   (fs_lat_o),
  .cpu_mode_o (cpu_mode_o),
  .mult_o     (mult_o),
  .pm_mode_o  (pm_mode_o),
  .fs_eff_o   (fs_eff_o),
  .clk_en_o   (clk_en_o),
  .pin_oe_o   (pin_oe_o)
);

// File: tb/strap_latch_top_tb.sv
module strap_latch_top_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] fs_strap_i = '0;
  logic       cpu_mode_strap_i = 1'b0;
  logic       mult_strap_i = 1'b0;
  logic       pm_mode_strap_i = 1'b0;
  logic       pwrgd_ni = 1'b1;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [3:0] fs_lat_o;
  logic       cpu_mode_o, mult_o, pm_mode_o, clk_en_o;
  logic [3:0] fs_eff_o;
  logic [7:0] pin_oe_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  strap_latch_top u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_img(input logic [3:0] fs, input logic ovr, input logic cpu);
    return {1'b0, fs[2], fs[1], fs[0], ovr, 1'b0, fs[3], cpu};
  endfunction

  function automatic logic [7:0] wr_img(input logic [3:0] fs, input logic ovr);
    return {1'b0, fs[2], fs[1], fs[0], ovr, 1'b0, fs[3], 1'b0};
  endfunction

  task automatic reg_wr(input logic [7:0] d);
    reg_we_i = 1'b1;
    reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    reg_wdata_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog (R1..) actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int cfg = 0; cfg < 128; cfg++) begin
      logic [3:0] fs, nf;
      logic mult, pm, cpu;
      fs = cfg[3:0]; mult = cfg[4]; pm = cfg[5]; cpu = cfg[6];
      rst_ni = 1'b0; pwrgd_ni = 1'b1; reg_we_i = 1'b0;
      fs_strap_i = fs; mult_strap_i = mult; pm_mode_strap_i = pm; cpu_mode_strap_i = cpu;
      @(negedge clk_i); @(negedge clk_i);
      chk("R1 clk_en in reset", clk_en_o, 0);
      chk("R1 pin_oe in reset", pin_oe_o, 0);
      chk("R1 fs_lat in reset", fs_lat_o, 0);
      chk("R1 rdata in reset", reg_rdata_o, 0);
      rst_ni = 1'b1;
      if (!cpu) begin
        @(negedge clk_i);
        chk("R2 mode0 capture", clk_en_o, 1);
      end else begin
        for (int k = 0; k <= cfg % 3; k++) begin
          @(negedge clk_i);
          chk("R3 wait for power-good", clk_en_o, 0);
          chk("R5 oe before capture", pin_oe_o, 0);
        end
        pwrgd_ni = 1'b0;
        @(negedge clk_i);
        chk("R3 capture on power-good low", clk_en_o, 1);
      end
      chk("R2 R3 fs_lat", fs_lat_o, fs);
      chk("R2 R3 straps", {cpu_mode_o, mult_o, pm_mode_o}, {cpu, mult, pm});
      chk("R5 pin_oe", pin_oe_o, {~cpu, 7'h7f});
      chk("R6 readback", reg_rdata_o, rd_img(fs, 1'b0, cpu));
      chk("R11 fs_eff", fs_eff_o, fs);

      // R4: later strap and power-good activity must not recapture
      fs_strap_i = ~fs; mult_strap_i = ~mult; pm_mode_strap_i = ~pm; cpu_mode_strap_i = ~cpu;
      pwrgd_ni = 1'b1;
      @(negedge clk_i);
      pwrgd_ni = 1'b0;
      @(negedge clk_i); @(negedge clk_i);
      chk("R4 fs_lat held", fs_lat_o, fs);
      chk("R4 straps held", {cpu_mode_o, mult_o, pm_mode_o}, {cpu, mult, pm});
      chk("R4 clk_en held", clk_en_o, 1);
      chk("R4 pin_oe held", pin_oe_o, {~cpu, 7'h7f});

      if (cfg % 8 == 3) begin
        nf = fs ^ 4'h5;
        reg_wr(wr_img(~fs, 1'b1));
        chk("R7 R10 enable write keeps code", fs_eff_o, fs);
        chk("R10 readback after enable", reg_rdata_o, rd_img(fs, 1'b1, cpu));
        reg_wr(wr_img(nf, 1'b1));
        chk("R8 software code", fs_eff_o, nf);
        chk("R8 readback software code", reg_rdata_o, rd_img(nf, 1'b1, cpu));
        chk("R8 fs_lat untouched", fs_lat_o, fs);
        reg_wr(8'h00);
        chk("R9 back to straps", fs_eff_o, fs);
        chk("R9 readback straps", reg_rdata_o, rd_img(fs, 1'b0, cpu));
        reg_wr(wr_img(~fs, 1'b0));
        chk("R7 locked write ignored", fs_eff_o, fs);
        chk("R7 locked readback", reg_rdata_o, rd_img(fs, 1'b0, cpu));
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule